// File: doc/BRIEF.md
# Indexed display register block

This block is the register front end of a display controller. Software reaches it through a small window of word-wide ports. A write to the index port selects one register. A later read or write on the value port then acts on that register. A third, auxiliary port returns a fixed constant and has no other effect.

The block holds the mode state: enable, requested width and height, and a colour depth fixed at build time. It also holds the identity word, the configuration-done flag, the sync/busy handshake to a command processor, the cursor registers, a guest identifier and a bank of scratch words. Derived read values are computed on the fly: bits per pixel, bytes per line and the framebuffer size latched at enable. Several writes have side effects:
- the identity register accepts only three version codes;
- a depth write that disagrees with the fixed depth drops configuration;
- a configuration-done write checks the four command-ring header words, which come in on input ports, before it sets the flag.

Top module: `disp_regif`

## Requirements
- R1: Port select 0 is the index port: writes load the index and reads return it. Select 1 is the value port. Select 2 reads 0x0000CAFE, and writes to it change no state.
- R2: After reset the identity register (index 0) reads 0x90000002. A write to it is kept only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves it unchanged.
- R3: A write to enable (index 1) stores the value, and reading index 1 returns it.
  - A zero write clears configuration-done.
  - A nonzero write latches the framebuffer size (index 16) as ((depth+7)>>3) × width × height, where width and height are the values last written to indices 2 and 3.
  - A write to index 1, 2 or 3 raises redraw_req for the one cycle after the write edge.
- R4: Index 6 reads the depth. Indices 7 and 28 read (depth+7) with the low three bits cleared. Index 12 reads ((depth+7)>>3) × width.
- R5: A write to index 6 or 7 with a value other than the depth clears configuration-done. A write with an equal value leaves it unchanged.
- R6: A nonzero write to configuration-done (index 20) sets the flag only when all of these hold:
  - ring_min, ring_max, ring_next and ring_stop are multiples of 4;
  - ring_min ≥ 16;
  - ring_max ≤ 0x10000;
  - ring_max ≥ ring_min + 10240.
  Otherwise the flag is left unchanged. A zero write clears it.
- R7: Writing 1 to cursor-on (index 27) sets the flag and writing 0 clears it. Writing 2 or 3 leaves it unchanged. Indices 24, 25 and 26 store and return cursor id, x and y.
- R8: Indices 1024 to 1791 read zero, ignore writes and do not raise bad_reg. Scratch words begin at index 1792. There are SCRATCH_WORDS of them, they read back what was written, and index 29 reads the count.
- R9: The capability word (index 17) has bit 0 set (fill) and bit 1 set (copy). Bits 5, 6 and 7 are also set when CURSOR_EN is 1.
- R10: The colour masks (indices 9, 10, 11 for red, green, blue) follow the depth:
  - depth 24 or 32: 0xFF0000, 0xFF00, 0xFF;
  - depth 16: 0x1F, 0x7E0, 0xF800;
  - depth 15: 0x1F, 0x3E0, 0x7C00;
  - depth 8: 0x07, 0x38, 0xC0.
- R11: A value-port read of an index outside the map returns zero. Such a read, or a value-port write to an index that is unmapped or read-only (for example 4), raises bad_reg for the one cycle after the access edge. The write changes no state.
- R12: A write to sync (index 21) sets busy and raises cmd_start for the one cycle after the write edge. Indices 21 and 22 read busy. Busy clears on the edge where cmd_done is high, unless a sync write arrives on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Port select: 0 index, 1 value, 2 auxiliary |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected port (combinational) |
| ring_min | input | 32 | Command-ring header: lower bound offset |
| ring_max | input | 32 | Command-ring header: upper bound offset |
| ring_next | input | 32 | Command-ring header: producer offset |
| ring_stop | input | 32 | Command-ring header: consumer offset |
| cmd_done | input | 1 | Command processor finished its run |
| cmd_start | output | 1 | One-cycle request to run the command processor |
| bad_reg | output | 1 | One-cycle flag for an access to an undefined register |
| redraw_req | output | 1 | One-cycle flag after a mode write |

## Verification
Most internal faults show up at the ports within one access. A wrong identity, configuration or cursor flag is returned on the very next value-port read of that index, because reads are combinational from the stored state. Faults in the side effects only appear through a later read: a config flag not cleared by a depth mismatch or a zero enable, or a size latched from the wrong operands. The bench therefore follows every side-effecting write with a read of the affected register. The pulse outputs are sampled in the single cycle after the access, so a pulse that is stuck, late or missing is caught there.

// File: rtl/disp_regif_pkg.sv
package disp_regif_pkg;

   typedef enum logic [1:0] {
      PORT_INDEX = 2'd0,
      PORT_VALUE = 2'd1,
      PORT_AUX   = 2'd2,
      PORT_NONE  = 2'd3
   } port_e;

   localparam logic [31:0] AUX_WORD = 32'h0000_CAFE;

   localparam logic [31:0] ID_VER0 = 32'h9000_0000;
   localparam logic [31:0] ID_VER1 = 32'h9000_0001;
   localparam logic [31:0] ID_VER2 = 32'h9000_0002;

   // register indices (fixed: software decodes them)
   localparam logic [31:0] IX_ID      = 32'd0;
   localparam logic [31:0] IX_ENABLE  = 32'd1;
   localparam logic [31:0] IX_WIDTH   = 32'd2;
   localparam logic [31:0] IX_HEIGHT  = 32'd3;
   localparam logic [31:0] IX_MAXW    = 32'd4;
   localparam logic [31:0] IX_MAXH    = 32'd5;
   localparam logic [31:0] IX_DEPTH   = 32'd6;
   localparam logic [31:0] IX_BPP     = 32'd7;
   localparam logic [31:0] IX_PSEUDO  = 32'd8;
   localparam logic [31:0] IX_RMASK   = 32'd9;
   localparam logic [31:0] IX_GMASK   = 32'd10;
   localparam logic [31:0] IX_BMASK   = 32'd11;
   localparam logic [31:0] IX_LINEB   = 32'd12;
   localparam logic [31:0] IX_FBSIZE  = 32'd16;
   localparam logic [31:0] IX_CAPS    = 32'd17;
   localparam logic [31:0] IX_CFGDONE = 32'd20;
   localparam logic [31:0] IX_SYNC    = 32'd21;
   localparam logic [31:0] IX_BUSY    = 32'd22;
   localparam logic [31:0] IX_GUEST   = 32'd23;
   localparam logic [31:0] IX_CURID   = 32'd24;
   localparam logic [31:0] IX_CURX    = 32'd25;
   localparam logic [31:0] IX_CURY    = 32'd26;
   localparam logic [31:0] IX_CURON   = 32'd27;
   localparam logic [31:0] IX_HOSTBPP = 32'd28;
   localparam logic [31:0] IX_SCRCNT  = 32'd29;
   localparam logic [31:0] IX_ZERO0   = 32'd30;
   localparam logic [31:0] IX_ZERO1   = 32'd31;
   localparam logic [31:0] IX_ZERO2   = 32'd32;
   localparam logic [31:0] PAL_FIRST  = 32'd1024;
   localparam logic [31:0] PAL_LAST   = 32'd1791;
   localparam logic [31:0] SCR_BASE   = 32'd1792;

   typedef struct packed {
      logic [31:0] red;
      logic [31:0] green;
      logic [31:0] blue;
   } cmask_t;

   function automatic cmask_t masks_for(input int depth);
      cmask_t m;
      case (depth)
         8:       m = '{red: 32'h07,     green: 32'h38,   blue: 32'hC0};
         15:      m = '{red: 32'h1F,     green: 32'h3E0,  blue: 32'h7C00};
         16:      m = '{red: 32'h1F,     green: 32'h7E0,  blue: 32'hF800};
         default: m = '{red: 32'hFF0000, green: 32'hFF00, blue: 32'hFF};
      endcase
      return m;
   endfunction

   function automatic logic id_accepted(input logic [31:0] v);
      return (v == ID_VER0) || (v == ID_VER1) || (v == ID_VER2);
   endfunction

endpackage

// File: rtl/disp_regif_hdr_chk.sv
module disp_regif_hdr_chk #(
   parameter int RING_BYTES = 65536,
   parameter int HDR_BYTES  = 16,
   parameter int MIN_SPAN   = 10240
) (
   input  logic [31:0] ring_min,
   input  logic [31:0] ring_max,
   input  logic [31:0] ring_next,
   input  logic [31:0] ring_stop,
   output logic        hdr_ok
);
   localparam logic [32:0] SPAN_W = 33'(MIN_SPAN);

   logic aligned, low_ok, high_ok, span_ok;

   always_comb begin
      aligned = ((ring_min | ring_max | ring_next | ring_stop) & 32'd3) == 32'd0;
      low_ok  = ring_min >= 32'(HDR_BYTES);
      high_ok = ring_max <= 32'(RING_BYTES);
      span_ok = {1'b0, ring_max} >= ({1'b0, ring_min} + SPAN_W);
      hdr_ok  = aligned && low_ok && high_ok && span_ok;
   end
endmodule

// File: rtl/disp_regif_scratch.sv
module disp_regif_scratch #(
   parameter int WORDS = 16,
   localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);
   logic [31:0] word_view [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                       word_q <= '0;
         else if (we && addr == AW'(g))    word_q <= wdata;
      end
      assign word_view[g] = word_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < WORDS; i++)
         if (addr == AW'(i)) rdata = word_view[i];
   end
endmodule

// File: rtl/disp_regif_sync.sv
module disp_regif_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_wr,
   input  logic done,
   output logic start,
   output logic busy
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start <= 1'b0;
         busy  <= 1'b0;
      end else begin
         start <= sync_wr;
         if (sync_wr)   busy <= 1'b1;
         else if (done) busy <= 1'b0;
      end
   end

   assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> busy);
   assert_done_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !sync_wr) |=> !busy);
endmodule

// File: rtl/disp_regif.sv
module disp_regif
   import disp_regif_pkg::*;
#(
   parameter int COLOR_DEPTH   = 24,
   parameter int DIM_W         = 12,
   parameter int MAX_W         = 2360,
   parameter int MAX_H         = 1770,
   parameter int SCRATCH_WORDS = 16,
   parameter bit CURSOR_EN     = 1'b1,
   parameter int RING_BYTES    = 65536,
   parameter int MIN_SPAN      = 10240
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  bus_sel,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [31:0] ring_min,
   input  logic [31:0] ring_max,
   input  logic [31:0] ring_next,
   input  logic [31:0] ring_stop,
   input  logic        cmd_done,
   output logic        cmd_start,
   output logic        bad_reg,
   output logic        redraw_req
);
   localparam int          BYPP     = (COLOR_DEPTH + 7) / 8;
   localparam logic [31:0] BPP_VAL  = 32'(BYPP * 8);
   localparam logic [31:0] DEPTH_W  = 32'(COLOR_DEPTH);
   localparam logic [31:0] BYPP_W   = 32'(BYPP);
   localparam cmask_t      MASKS    = masks_for(COLOR_DEPTH);
   localparam logic [31:0] CAPS     = 32'h3 | (CURSOR_EN ? 32'hE0 : 32'h0);
   localparam logic [31:0] SCR_END  = SCR_BASE + 32'(SCRATCH_WORDS);
   localparam int          SAW      = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;

   // elaboration-time parameter checks
   if (!(COLOR_DEPTH == 8 || COLOR_DEPTH == 15 || COLOR_DEPTH == 16 ||
         COLOR_DEPTH == 24 || COLOR_DEPTH == 32)) begin : g_bad_depth
      $error("disp_regif: unsupported COLOR_DEPTH %0d", COLOR_DEPTH);
   end
   if (SCRATCH_WORDS < 1 || SCRATCH_WORDS > 4096) begin : g_bad_scratch
      $error("disp_regif: SCRATCH_WORDS out of range");
   end
   if (DIM_W < 1 || DIM_W > 16) begin : g_bad_dim
      $error("disp_regif: DIM_W out of range");
   end

   // state
   logic [31:0]      index_q, id_q, enable_q, fbsize_q, guest_q;
   logic [31:0]      cur_id_q, cur_x_q, cur_y_q;
   logic [DIM_W-1:0] new_w_q, new_h_q;
   logic             config_q, cur_on_q, bad_q, redraw_q;

   // decode
   logic val_wr, val_rd, idx_wr, is_pal, is_scr;
   logic rd_known, wr_known;
   logic [31:0] rd_val, scr_rdata;
   logic [SAW-1:0] scr_addr;
   logic hdr_ok, busy, sync_wr;

   always_comb begin
      val_wr   = bus_wr && (bus_sel == PORT_VALUE);
      val_rd   = bus_rd && (bus_sel == PORT_VALUE);
      idx_wr   = bus_wr && (bus_sel == PORT_INDEX);
      is_pal   = (index_q >= PAL_FIRST) && (index_q <= PAL_LAST);
      is_scr   = (index_q >= SCR_BASE) && (index_q < SCR_END);
      scr_addr = SAW'(index_q - SCR_BASE);
      sync_wr  = val_wr && (index_q == IX_SYNC);
   end

   disp_regif_hdr_chk #(
      .RING_BYTES(RING_BYTES), .HDR_BYTES(16), .MIN_SPAN(MIN_SPAN)
   ) hdr_i (
      .ring_min(ring_min), .ring_max(ring_max),
      .ring_next(ring_next), .ring_stop(ring_stop), .hdr_ok(hdr_ok)
   );

   disp_regif_scratch #(.WORDS(SCRATCH_WORDS)) scr_i (
      .clk(clk), .rst_n(rst_n), .we(val_wr && is_scr),
      .addr(scr_addr), .wdata(bus_wdata), .rdata(scr_rdata)
   );

   disp_regif_sync sync_i (
      .clk(clk), .rst_n(rst_n), .sync_wr(sync_wr), .done(cmd_done),
      .start(cmd_start), .busy(busy)
   );

   // read map
   always_comb begin
      rd_known = 1'b1;
      rd_val   = '0;
      case (index_q)
         IX_ID:                  rd_val = id_q;
         IX_ENABLE:              rd_val = enable_q;
         IX_WIDTH:               rd_val = 32'(new_w_q);
         IX_HEIGHT:              rd_val = 32'(new_h_q);
         IX_MAXW:                rd_val = 32'(MAX_W);
         IX_MAXH:                rd_val = 32'(MAX_H);
         IX_DEPTH:               rd_val = DEPTH_W;
         IX_BPP, IX_HOSTBPP:     rd_val = BPP_VAL;
         IX_PSEUDO:              rd_val = '0;
         IX_RMASK:               rd_val = MASKS.red;
         IX_GMASK:               rd_val = MASKS.green;
         IX_BMASK:               rd_val = MASKS.blue;
         IX_LINEB:               rd_val = BYPP_W * 32'(new_w_q);
         IX_FBSIZE:              rd_val = fbsize_q;
         IX_CAPS:                rd_val = CAPS;
         IX_CFGDONE:             rd_val = {31'd0, config_q};
         IX_SYNC, IX_BUSY:       rd_val = {31'd0, busy};
         IX_GUEST:               rd_val = guest_q;
         IX_CURID:               rd_val = cur_id_q;
         IX_CURX:                rd_val = cur_x_q;
         IX_CURY:                rd_val = cur_y_q;
         IX_CURON:               rd_val = {31'd0, cur_on_q};
         IX_SCRCNT:              rd_val = 32'(SCRATCH_WORDS);
         IX_ZERO0, IX_ZERO1, IX_ZERO2: rd_val = '0;
         default: begin
            if (is_scr)      rd_val = scr_rdata;
            else if (!is_pal) rd_known = 1'b0;
         end
      endcase
   end

   // write map: only these indices accept value-port writes
   always_comb begin
      case (index_q)
         IX_ID, IX_ENABLE, IX_WIDTH, IX_HEIGHT, IX_DEPTH, IX_BPP,
         IX_CFGDONE, IX_SYNC, IX_GUEST, IX_CURID, IX_CURX, IX_CURY,
         IX_CURON, IX_ZERO0, IX_ZERO1, IX_ZERO2: wr_known = 1'b1;
         default: wr_known = is_pal || is_scr;
      endcase
   end

   always_comb begin
      case (bus_sel)
         PORT_INDEX: bus_rdata = index_q;
         PORT_VALUE: bus_rdata = rd_val;
         PORT_AUX:   bus_rdata = AUX_WORD;
         default:    bus_rdata = '0;
      endcase
   end

   // register updates
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q  <= '0;
         id_q     <= ID_VER2;
         enable_q <= '0;
         fbsize_q <= '0;
         guest_q  <= '0;
         cur_id_q <= '0;
         cur_x_q  <= '0;
         cur_y_q  <= '0;
         new_w_q  <= '0;
         new_h_q  <= '0;
         config_q <= 1'b0;
         cur_on_q <= 1'b0;
         bad_q    <= 1'b0;
         redraw_q <= 1'b0;
      end else begin
         bad_q    <= (val_rd && !rd_known) || (val_wr && !wr_known);
         redraw_q <= val_wr && (index_q == IX_ENABLE || index_q == IX_WIDTH ||
                                index_q == IX_HEIGHT);
         if (idx_wr) index_q <= bus_wdata;
         if (val_wr) begin
            case (index_q)
               IX_ID: if (id_accepted(bus_wdata)) id_q <= bus_wdata;
               IX_ENABLE: begin
                  enable_q <= bus_wdata;
                  if (bus_wdata == '0) config_q <= 1'b0;
                  else fbsize_q <= BYPP_W * 32'(new_w_q) * 32'(new_h_q);
               end
               IX_WIDTH:  new_w_q <= bus_wdata[DIM_W-1:0];
               IX_HEIGHT: new_h_q <= bus_wdata[DIM_W-1:0];
               IX_DEPTH, IX_BPP: if (bus_wdata != DEPTH_W) config_q <= 1'b0;
               IX_CFGDONE: begin
                  if (bus_wdata == '0) config_q <= 1'b0;
                  else if (hdr_ok)     config_q <= 1'b1;
               end
               IX_GUEST: guest_q  <= bus_wdata;
               IX_CURID: cur_id_q <= bus_wdata;
               IX_CURX:  cur_x_q  <= bus_wdata;
               IX_CURY:  cur_y_q  <= bus_wdata;
               IX_CURON: begin
                  if (bus_wdata == 32'd1)      cur_on_q <= 1'b1;
                  else if (bus_wdata == 32'd0) cur_on_q <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   assign bad_reg    = bad_q;
   assign redraw_req = redraw_q;

   // assertions
   assert_id_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (id_q == ID_VER0) || (id_q == ID_VER1) || (id_q == ID_VER2));
   assert_cfg_needs_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (val_wr && index_q == IX_CFGDONE && bus_wdata != '0 && !hdr_ok && !config_q)
      |=> !config_q);
   assert_curon_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (val_wr && index_q == IX_CURON && bus_wdata >= 32'd2) |=> $stable(cur_on_q));
   assert_aux_noeffect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == PORT_AUX) |=> ($stable(index_q) && $stable(config_q)));
   assert_pal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (val_wr && is_pal) |=> !bad_reg);
   assert_enable0_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (val_wr && index_q == IX_ENABLE && bus_wdata == '0) |=> !config_q);
endmodule

// File: tb/disp_regif_tb_top.sv
`timescale 1ns/1ps
module disp_regif_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_sel = 2'd3;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] ring_min = 32'd16, ring_max = 32'h10000, ring_next = 32'd16, ring_stop = 32'd16;
   logic        cmd_done = 1'b0;
   logic        cmd_start, bad_reg, redraw_req;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];

   always #5 clk = ~clk;

   disp_regif dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ring_min(ring_min), .ring_max(ring_max), .ring_next(ring_next), .ring_stop(ring_stop),
      .cmd_done(cmd_done), .cmd_start(cmd_start), .bad_reg(bad_reg), .redraw_req(redraw_req)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares value on every read strobe against the scoreboard
   always @(negedge clk) begin
      if (bus_rd) begin
         if (sbq.size() == 0) chk(32'hDEAD, 32'h0, "scoreboard empty");
         else begin
            item_t it;
            it = sbq.pop_front();
            chk(bus_rdata, it.exp, it.tag);
         end
      end
   end

   task automatic put(input logic [1:0] sel, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_sel = 2'd3;
   endtask

   task automatic get(input logic [1:0] sel, input logic [31:0] exp, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      bus_sel = sel; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_sel = 2'd3;
   endtask

   task automatic reg_wr(input logic [31:0] idx, input logic [31:0] v);
      put(2'd0, idx);
      put(2'd1, v);
   endtask

   task automatic reg_rd(input logic [31:0] idx, input logic [31:0] exp, input string tag);
      put(2'd0, idx);
      get(2'd1, exp, tag);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      reg_rd(0, 32'h9000_0002, "R2 reset id");
      reg_rd(20, 0, "R6 reset config");
      reg_rd(22, 0, "R12 reset busy");
      reg_rd(27, 0, "R7 reset cursor on");
      reg_rd(1, 0, "R3 reset enable");
      reg_rd(9, 32'hFF0000, "R10 red mask");
      reg_rd(10, 32'hFF00, "R10 green mask");
      reg_rd(11, 32'hFF, "R10 blue mask");

      // ports
      put(2'd0, 32'd123);
      get(2'd0, 32'd123, "R1 index readback");
      get(2'd2, 32'h0000_CAFE, "R1 aux read");
      put(2'd2, 32'd55);
      get(2'd0, 32'd123, "R1 aux write ignored");

      // identity filter
      reg_wr(0, 32'h9000_0000);
      reg_rd(0, 32'h9000_0000, "R2 accept ver0");
      reg_wr(0, 32'h1234_5678);
      reg_rd(0, 32'h9000_0000, "R2 reject other");
      reg_wr(0, 32'h9000_0003);
      reg_rd(0, 32'h9000_0000, "R2 reject ver3");

      // mode size
      reg_wr(2, 640);
      chk({31'd0, redraw_req}, 1, "R3 redraw after width");
      reg_wr(3, 480);
      reg_rd(7, 24, "R4 bpp");
      reg_rd(28, 24, "R4 host bpp");
      reg_rd(6, 24, "R4 depth");
      reg_rd(12, 1920, "R4 bytes per line");

      // config validation
      reg_wr(20, 1);
      reg_rd(20, 1, "R6 good header sets");
      reg_wr(20, 0);
      reg_rd(20, 0, "R6 zero clears");
      ring_max = 32'd16 + 32'd10236;
      reg_wr(20, 1);
      reg_rd(20, 0, "R6 span too small");
      ring_max = 32'd16 + 32'd10240;
      reg_wr(20, 1);
      reg_rd(20, 1, "R6 exact span boundary");
      reg_wr(20, 0);
      ring_next = 32'd18;
      reg_wr(20, 1);
      reg_rd(20, 0, "R6 misaligned next");
      ring_next = 32'd16; ring_min = 32'd12; ring_max = 32'h8000;
      reg_wr(20, 1);
      reg_rd(20, 0, "R6 min below 16");
      ring_min = 32'd16; ring_max = 32'h10004;
      reg_wr(20, 1);
      reg_rd(20, 0, "R6 max above ring");
      ring_max = 32'h10000;
      reg_wr(20, 1);
      reg_rd(20, 1, "R6 restore");

      // depth checks
      reg_wr(6, 24);
      reg_rd(20, 1, "R5 equal depth keeps config");
      reg_wr(6, 16);
      reg_rd(20, 0, "R5 depth mismatch clears");
      reg_wr(20, 1);
      reg_wr(7, 32);
      reg_rd(20, 0, "R5 bpp mismatch clears");

      // enable
      reg_wr(20, 1);
      reg_wr(1, 1);
      chk({31'd0, redraw_req}, 1, "R3 redraw after enable");
      reg_rd(1, 1, "R3 enable stored");
      reg_rd(16, 32'd921600, "R3 fb size");
      reg_rd(20, 1, "R3 nonzero enable keeps config");
      reg_wr(1, 0);
      reg_rd(20, 0, "R3 zero enable clears config");

      // cursor
      reg_wr(27, 1);  reg_rd(27, 1, "R7 on=1 sets");
      reg_wr(27, 2);  reg_rd(27, 1, "R7 on=2 holds set");
      reg_wr(27, 3);  reg_rd(27, 1, "R7 on=3 holds set");
      reg_wr(27, 0);  reg_rd(27, 0, "R7 on=0 clears");
      reg_wr(27, 2);  reg_rd(27, 0, "R7 on=2 holds clear");
      reg_wr(25, 77); reg_wr(26, 99);
      reg_rd(25, 77, "R7 cursor x");
      reg_rd(26, 99, "R7 cursor y");

      // palette and scratch
      reg_wr(1024, 32'hAAAA);
      chk({31'd0, bad_reg}, 0, "R8 palette write no bad");
      reg_rd(1024, 0, "R8 palette reads zero");
      reg_rd(1791, 0, "R8 palette top reads zero");
      reg_wr(1792, 32'h1111_2222);
      reg_wr(1807, 32'h3333_4444);
      reg_rd(1792, 32'h1111_2222, "R8 scratch first");
      reg_rd(1807, 32'h3333_4444, "R8 scratch last");
      reg_rd(29, 16, "R8 scratch count");

      // undefined
      reg_rd(1808, 0, "R11 past scratch reads zero");
      chk({31'd0, bad_reg}, 1, "R11 bad pulse on read");
      @(posedge clk); #1;
      chk({31'd0, bad_reg}, 0, "R11 bad pulse one cycle");
      reg_rd(40, 0, "R11 hole reads zero");
      reg_wr(4, 5);
      chk({31'd0, bad_reg}, 1, "R11 bad pulse on read-only write");
      reg_rd(4, 2360, "R11 read-only unchanged");

      // capabilities
      reg_rd(17, 32'hE3, "R9 capability word");

      // sync
      reg_wr(21, 1);
      chk({31'd0, cmd_start}, 1, "R12 start pulse");
      @(posedge clk); #1;
      chk({31'd0, cmd_start}, 0, "R12 start one cycle");
      reg_rd(22, 1, "R12 busy set");
      reg_rd(21, 1, "R12 sync reads busy");
      @(posedge clk); #1 cmd_done = 1'b1;
      @(posedge clk); #1 cmd_done = 1'b0;
      reg_rd(22, 0, "R12 done clears busy");

      repeat (3) @(posedge clk);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule